// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block multiplies two 18-bit operands and folds each 36-bit product into a 52-bit running total. The total has sixteen guard bits above the product width. Each operand is signed (two's complement) or unsigned, chosen per operand on every cycle. On each cycle the product is added to the total, subtracted from it, or loaded into it in place of the old total. A sticky flag reports that the total has left the 52-bit range in either direction.

The operands are captured in input registers, which also drive shift-out ports. Each operand register is fed either from the parallel data input or from a shift-in port, so a row of units can pass operands down a delay chain. The pipeline has three register levels: operand, product and accumulator. The control signals pass through their own short delay lines, so a control value presented with its operands acts on those same operands. One clock, one asynchronous active-high clear and one clock enable serve every register.

Top module: `mac_unit`

## Requirements
- R1: While `clr` is high, `acc_out`, `ovf`, `shout_a` and `shout_b` are all zero, and the pipeline holds only zero products with add selected.
- R2: With default parameters, the operands and controls presented before enabled edge k act on `acc_out` and `ovf` at enabled edge k+2. This is the third enabled edge that counts edge k as the first.
- R3: `sign_a` and `sign_b` mark `data_a` and `data_b` as two's complement when 1 and as unsigned when 0. The total is treated as signed when either operand is signed, and as unsigned otherwise.
- R4: `sub` = 1 subtracts the product from the total. `sub` = 0 adds it.
- R5: `sload` = 1 replaces the total with the product, extended to 52 bits. `sub` is ignored on a load, and the load clears `ovf`.
- R6: `ovf` goes high when the exact sum leaves the 52-bit range. The range is [-2^51, 2^51-1] when the total is signed and [0, 2^52-1] when it is unsigned. The total keeps the low 52 bits of the sum, and `ovf` stays high until a load or a clear.
- R7: While `ena` is low, no register changes: the outputs hold, and the pipeline contents resume unchanged once `ena` returns.
- R8: `shsel_a` = 1 (likewise `shsel_b`) takes the operand from `shin_a` in place of `data_a`. After each enabled edge, `shout_a` and `shout_b` show the operand values captured at that edge.
- R9: Under the default parameters, one sign-control stage and two accumulate-control stages, controls presented together with their operands apply to exactly those operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register |
| clr | input | 1 | Asynchronous clear, active high |
| ena | input | 1 | Clock enable; low holds all state |
| data_a | input | 18 | Parallel operand A |
| data_b | input | 18 | Parallel operand B |
| shin_a | input | 18 | Chained operand A from the previous unit |
| shin_b | input | 18 | Chained operand B from the previous unit |
| shsel_a | input | 1 | 1 = take A from shin_a |
| shsel_b | input | 1 | 1 = take B from shin_b |
| sign_a | input | 1 | 1 = operand A is two's complement |
| sign_b | input | 1 | 1 = operand B is two's complement |
| sub | input | 1 | 1 = subtract product, 0 = add |
| sload | input | 1 | 1 = load product into the total |
| shout_a | output | 18 | Registered operand A for the next unit |
| shout_b | output | 18 | Registered operand B for the next unit |
| acc_out | output | 52 | Accumulated total |
| ovf | output | 1 | Sticky overflow/underflow flag |

## Verification
A wrong product or a misaligned control appears in `acc_out` exactly three enabled edges after the offending operands. Because the total is cumulative, the error then persists until the next load. A bad overflow rule shows as `ovf` rising one edge too early or too late at the range boundary, or as `ovf` failing to stay high afterwards. Stale operand registers show on the shift-out ports one edge after capture. For these reasons the outputs are compared against a reference model on every clock.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int OP_W    = 18;
  localparam int GUARD_W = 16;

  typedef struct packed {
    logic sub;
    logic sload;
  } acc_ctl_t;

  typedef struct packed {
    logic sa;
    logic sb;
  } sgn_ctl_t;
endpackage

// File: rtl/mac_ctrl_delay.sv
module mac_ctrl_delay #(
  parameter int W      = 2,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ena,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_reg
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else if (ena) begin
          stg[0] <= d;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mac_operand_reg.sv
module mac_operand_reg #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ena,
  input  logic [W-1:0] par_in,
  input  logic [W-1:0] chain_in,
  input  logic         use_chain,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or posedge clr) begin
    if (clr)      q <= '0;
    else if (ena) q <= use_chain ? chain_in : par_in;
  end
endmodule

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
  parameter int OP_W = 18,
  localparam int PW  = 2*OP_W + 1
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            ena,
  input  logic [OP_W-1:0] a,
  input  logic [OP_W-1:0] b,
  input  logic            sa,
  input  logic            sb,
  output logic [PW-1:0]   prod_q,
  output logic            psigned_q
);
  logic [PW-1:0] ax, bx, prod_n;

  assign ax     = {{(PW-OP_W){sa & a[OP_W-1]}}, a};
  assign bx     = {{(PW-OP_W){sb & b[OP_W-1]}}, b};
  assign prod_n = ax * bx;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      prod_q    <= '0;
      psigned_q <= 1'b0;
    end else if (ena) begin
      prod_q    <= prod_n;
      psigned_q <= sa | sb;
    end
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int PIN_W = 37,
  parameter int ACC_W = 52,
  localparam int EXT_W = ACC_W + 1
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ena,
  input  logic [PIN_W-1:0] prod,
  input  logic             psigned,
  input  logic             sub,
  input  logic             sload,
  output logic [ACC_W-1:0] acc_q,
  output logic             ovf_q
);
  logic [EXT_W-1:0] prod_ext, acc_ext, sum;
  logic             ovf_now;

  assign prod_ext = {{(EXT_W-PIN_W){prod[PIN_W-1]}}, prod};
  assign acc_ext  = {psigned & acc_q[ACC_W-1], acc_q};
  assign sum      = sub ? (acc_ext - prod_ext) : (acc_ext + prod_ext);
  assign ovf_now  = psigned ? (sum[EXT_W-1] ^ sum[EXT_W-2]) : sum[EXT_W-1];

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (ena) begin
      if (sload) begin
        acc_q <= prod_ext[ACC_W-1:0];
        ovf_q <= 1'b0;
      end else begin
        acc_q <= sum[ACC_W-1:0];
        ovf_q <= ovf_q | ovf_now;
      end
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int OP_W        = mac_pkg::OP_W,
  parameter int GUARD_W     = mac_pkg::GUARD_W,
  parameter int SIGN_STAGES = 1,
  parameter int ACC_STAGES  = 2,
  localparam int PROD_W     = 2*OP_W,
  localparam int ACC_W      = PROD_W + GUARD_W
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ena,
  input  logic [OP_W-1:0]  data_a,
  input  logic [OP_W-1:0]  data_b,
  input  logic [OP_W-1:0]  shin_a,
  input  logic [OP_W-1:0]  shin_b,
  input  logic             shsel_a,
  input  logic             shsel_b,
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic             sub,
  input  logic             sload,
  output logic [OP_W-1:0]  shout_a,
  output logic [OP_W-1:0]  shout_b,
  output logic [ACC_W-1:0] acc_out,
  output logic             ovf
);
  import mac_pkg::*;

  sgn_ctl_t          sgn_d;
  acc_ctl_t          acc_ctl_d;
  logic [PROD_W:0]   prod_q;
  logic              psigned_q;
  logic              load_now;

  mac_operand_reg #(.W(OP_W)) u_opa (
    .clk(clk), .clr(clr), .ena(ena),
    .par_in(data_a), .chain_in(shin_a), .use_chain(shsel_a), .q(shout_a)
  );

  mac_operand_reg #(.W(OP_W)) u_opb (
    .clk(clk), .clr(clr), .ena(ena),
    .par_in(data_b), .chain_in(shin_b), .use_chain(shsel_b), .q(shout_b)
  );

  mac_ctrl_delay #(.W(2), .STAGES(SIGN_STAGES)) u_sgn_dly (
    .clk(clk), .clr(clr), .ena(ena), .d({sign_a, sign_b}), .q(sgn_d)
  );

  mac_ctrl_delay #(.W(2), .STAGES(ACC_STAGES)) u_acc_dly (
    .clk(clk), .clr(clr), .ena(ena), .d({sub, sload}), .q(acc_ctl_d)
  );

  mac_multiplier #(.OP_W(OP_W)) u_mul (
    .clk(clk), .clr(clr), .ena(ena),
    .a(shout_a), .b(shout_b), .sa(sgn_d.sa), .sb(sgn_d.sb),
    .prod_q(prod_q), .psigned_q(psigned_q)
  );

  assign load_now = acc_ctl_d.sload;

  mac_accum #(.PIN_W(PROD_W+1), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .clr(clr), .ena(ena),
    .prod(prod_q), .psigned(psigned_q),
    .sub(acc_ctl_d.sub), .sload(load_now),
    .acc_q(acc_out), .ovf_q(ovf)
  );
endmodule

// File: rtl/mac_unit_checker.sv
module mac_unit_checker #(
  parameter int OP_W  = 18,
  parameter int ACC_W = 52
) (
  input logic             clk,
  input logic             clr,
  input logic             ena,
  input logic [OP_W-1:0]  data_a,
  input logic [OP_W-1:0]  data_b,
  input logic [OP_W-1:0]  shin_a,
  input logic [OP_W-1:0]  shin_b,
  input logic             shsel_a,
  input logic             shsel_b,
  input logic [OP_W-1:0]  shout_a,
  input logic [OP_W-1:0]  shout_b,
  input logic [ACC_W-1:0] acc_out,
  input logic             ovf,
  input logic             load_now
);
  always @(posedge clk) begin
    if (clr) begin
      AST_CLEAR_STATE: assert (acc_out == '0 && !ovf && shout_a == '0 && shout_b == '0); // R1
    end
  end

  AST_HOLD_ON_IDLE: assert property (@(posedge clk) disable iff (clr)
    !ena |=> ($stable(acc_out) && $stable(ovf) && $stable(shout_a) && $stable(shout_b))); // R7

  AST_SHIFT_OUT_A: assert property (@(posedge clk) disable iff (clr)
    ena |=> shout_a == $past(shsel_a ? shin_a : data_a)); // R8

  AST_SHIFT_OUT_B: assert property (@(posedge clk) disable iff (clr)
    ena |=> shout_b == $past(shsel_b ? shin_b : data_b)); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (clr)
    (ena && ovf && !load_now) |=> ovf); // R6

  AST_LOAD_CLEARS_FLAG: assert property (@(posedge clk) disable iff (clr)
    (ena && load_now) |=> !ovf); // R5
endmodule

bind mac_unit mac_unit_checker #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .clr(clr), .ena(ena),
  .data_a(data_a), .data_b(data_b), .shin_a(shin_a), .shin_b(shin_b),
  .shsel_a(shsel_a), .shsel_b(shsel_b), .shout_a(shout_a), .shout_b(shout_b),
  .acc_out(acc_out), .ovf(ovf), .load_now(load_now)
);

// File: tb/mac_unit_bench.sv
`timescale 1ns/1ps
module mac_unit_bench;
  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic        ena = 1'b0;
  logic [17:0] data_a = '0, data_b = '0, shin_a = '0, shin_b = '0;
  logic        shsel_a = 1'b0, shsel_b = 1'b0;
  logic        sign_a = 1'b0, sign_b = 1'b0, sub = 1'b0, sload = 1'b0;
  logic [17:0] shout_a, shout_b;
  logic [51:0] acc_out;
  logic        ovf;

  always #2.5 clk = ~clk;

  mac_unit u_mac_unit (
    .clk(clk), .clr(clr), .ena(ena),
    .data_a(data_a), .data_b(data_b), .shin_a(shin_a), .shin_b(shin_b),
    .shsel_a(shsel_a), .shsel_b(shsel_b), .sign_a(sign_a), .sign_b(sign_b),
    .sub(sub), .sload(sload), .shout_a(shout_a), .shout_b(shout_b),
    .acc_out(acc_out), .ovf(ovf)
  );

  typedef struct {
    longint p;
    bit     s;
    bit     sb;
    bit     ld;
  } txn_t;

  localparam longint LIM51 = 64'sd1 <<< 51;
  localparam longint LIM52 = 64'sd1 <<< 52;

  txn_t        pipe_q[$];
  logic [51:0] m_acc;
  bit          m_ovf;
  logic [17:0] m_sha, m_shb;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 0;
  string       cur_req = "R1";

  task automatic model_reset();
    txn_t z;
    z.p = 0; z.s = 0; z.sb = 0; z.ld = 0;
    pipe_q.delete();
    pipe_q.push_back(z);
    pipe_q.push_back(z);
    m_acc = '0; m_ovf = 0; m_sha = '0; m_shb = '0;
  endtask

  task automatic apply_txn(input txn_t t);
    longint accx, sum;
    bit     o;
    if (t.ld) begin
      m_acc = t.p[51:0];
      m_ovf = 0;
    end else begin
      accx = t.s ? longint'($signed(m_acc)) : longint'(m_acc);
      sum  = t.sb ? accx - t.p : accx + t.p;
      if (t.s) o = (sum < -LIM51) || (sum >= LIM51);
      else     o = (sum < 0) || (sum >= LIM52);
      m_ovf = m_ovf | o;
      m_acc = sum[51:0];
    end
  endtask

  task automatic model_edge();
    logic [17:0] av, bv;
    longint      ai, bi;
    txn_t        t;
    if (!ena) return;
    av = shsel_a ? shin_a : data_a;
    bv = shsel_b ? shin_b : data_b;
    m_sha = av; m_shb = bv;
    ai = sign_a ? longint'($signed(av)) : longint'(av);
    bi = sign_b ? longint'($signed(bv)) : longint'(bv);
    t.p = ai * bi; t.s = sign_a | sign_b; t.sb = sub; t.ld = sload;
    pipe_q.push_back(t);
    if (pipe_q.size() == 3) apply_txn(pipe_q.pop_front());
  endtask

  task automatic compare();
    n_tests++;
    if (acc_out !== m_acc || ovf !== m_ovf || shout_a !== m_sha || shout_b !== m_shb) begin
      n_fail++;
      $display("FAIL %s: actual acc=%h ovf=%b sha=%h shb=%h expected acc=%h ovf=%b sha=%h shb=%h",
               cur_req, acc_out, ovf, shout_a, shout_b, m_acc, m_ovf, m_sha, m_shb);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    compare();
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(posedge clk);
    #1;
    model_reset();
    compare();
    clr = 1'b0;
  endtask

  task automatic op(input logic [17:0] a, input logic [17:0] b,
                    input bit sa, input bit sbb, input bit s_sub, input bit ld);
    ena = 1'b1; shsel_a = 1'b0; shsel_b = 1'b0;
    data_a = a; data_b = b; sign_a = sa; sign_b = sbb; sub = s_sub; sload = ld;
    step();
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) op(18'd0, 18'd0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2: watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: clear state
    cur_req = "R1";
    repeat (2) @(posedge clk);
    do_clear();

    // R2 R9: latency and control alignment
    cur_req = "R2,R9";
    op(18'd3, 18'd5, 0, 0, 0, 1);
    op(18'd7, 18'd9, 0, 0, 0, 0);
    op(18'd2, 18'd2, 0, 0, 1, 0);
    flush();

    // R3: signedness per operand
    cur_req = "R3";
    op(18'h3FFFE, 18'd3, 1, 0, 0, 1);    // -2 * 3
    op(18'h3FFFC, 18'h3FFFB, 1, 1, 0, 0); // -4 * -5
    op(18'h3FFFF, 18'd1, 0, 0, 0, 1);     // unsigned max * 1
    op(18'h20000, 18'h3FFFF, 1, 0, 0, 0);  // signed min * unsigned max
    flush();

    // R4: subtract
    cur_req = "R4";
    op(18'd100, 18'd100, 0, 0, 0, 1);
    op(18'd10, 18'd10, 0, 0, 1, 0);
    op(18'd5, 18'h3FFFF, 0, 1, 1, 0);     // subtract 5 * -1
    flush();

    // R5: load ignores sub and clears flag
    cur_req = "R5";
    op(18'd0, 18'd0, 0, 0, 0, 1);
    op(18'd1, 18'd1, 0, 0, 1, 0);         // unsigned underflow
    op(18'd6, 18'd7, 0, 0, 1, 1);         // load +42 despite sub
    flush();

    // R7: enable low holds everything
    cur_req = "R7";
    op(18'd11, 18'd13, 0, 0, 0, 0);
    op(18'd17, 18'd19, 0, 0, 0, 0);
    ena = 1'b0;
    for (int i = 0; i < 6; i++) begin
      data_a = 18'($urandom); data_b = 18'($urandom); sload = 1'b1; sub = 1'b1;
      step();
    end
    flush();

    // R8: operand chain selection
    cur_req = "R8";
    for (int i = 0; i < 40; i++) begin
      ena = 1'b1;
      shsel_a = 1'($urandom); shsel_b = 1'($urandom);
      data_a = 18'($urandom); data_b = 18'($urandom);
      shin_a = 18'($urandom); shin_b = 18'($urandom);
      sign_a = 1'($urandom); sign_b = 1'($urandom);
      sub = 1'($urandom); sload = (i % 9 == 0);
      step();
    end
    flush();

    // R3 R4 mixed random traffic with enable gaps
    cur_req = "R3,R4";
    for (int i = 0; i < 300; i++) begin
      ena = ($urandom % 5) != 0;
      shsel_a = 1'b0; shsel_b = 1'b0;
      data_a = 18'($urandom); data_b = 18'($urandom);
      sign_a = 1'($urandom); sign_b = 1'($urandom);
      sub = 1'($urandom); sload = ($urandom % 8) == 0;
      step();
    end
    flush();

    // R1: clear in the middle of traffic
    cur_req = "R1";
    op(18'd99, 18'd99, 0, 0, 0, 1);
    op(18'd99, 18'd99, 0, 0, 0, 0);
    do_clear();
    flush();

    // R6: signed underflow after unsigned growth past 2^51
    cur_req = "R6";
    op(18'h3FFFF, 18'h3FFFF, 0, 0, 0, 1);
    for (int i = 0; i < 32769; i++) op(18'h3FFFF, 18'h3FFFF, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) op(18'h20000, 18'h20000, 1, 1, 1, 0);
    flush();

    // R6: signed overflow upward
    op(18'h3FFFF, 18'h3FFFF, 0, 0, 0, 1);
    for (int i = 0; i < 32759; i++) op(18'h3FFFF, 18'h3FFFF, 0, 0, 0, 0);
    for (int i = 0; i < 100; i++) op(18'h20000, 18'h20000, 1, 1, 0, 0);
    flush();

    // R6: unsigned overflow from all-ones, then unsigned underflow from zero
    op(18'd0, 18'd0, 1, 1, 0, 1);
    op(18'd1, 18'd1, 1, 1, 1, 0);
    op(18'd1, 18'd1, 0, 0, 0, 0);
    op(18'd0, 18'd0, 0, 0, 0, 0);
    op(18'd0, 18'd0, 0, 0, 0, 1);
    op(18'd1, 18'd1, 0, 0, 1, 0);
    flush();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule